// File: doc/BRIEF.md
# Cascadable Serial Configuration Stream Reader

This block holds a small fixed bitstream and sends it to a programmable logic device, one bit or one byte per rising edge of an external configuration clock. The configuration clock comes from the target device and is asynchronous to the block's system clock. It passes through a synchronizer, and each of its rising edges becomes a one-cycle strobe. Internal byte-address and bit counters pick the next item from the array. Each byte goes out most significant bit first.

Several instances can share one configuration clock and one data line. An instance drives the line only while its active-low chip enable is low. After its last item has been read, the next valid clock edge drives its active-low cascade output low and releases the line. A downstream instance whose chip enable is wired to that cascade output then starts from its own first bit. The line is modelled as a value plus a drive-enable, so handover can be checked for contention. An active-low output-enable/reset input stops driving and clears the counters. A rising configuration request produces an active-low reconfigure pulse of fixed length, which restarts the target device.

Top module: `cfg_stream_reader`

## Requirements
- R1: After the system reset is released, the instance is in serial mode at byte 0 bit 7. `rcfg_n` and `ceo_n` are high, and with `ce_n` low the instance drives `data_q[0]` equal to bit 7 of byte 0.
- R2: Stored byte `a` (0 to DEPTH-1) equals `(a*29 + SEED) mod 256`.
- R3: In serial mode each valid edge moves to the next bit. Bits go out MSB first on `data_q[0]`, and `data_q[7:1]` reads 0.
- R4: `cfg_clk` passes through SYNC_STAGES flops. A rising edge first sampled by system-clock edge k advances the counters at edge k+SYNC_STAGES (k+2 by default).
- R5: A `cfg_clk` edge whose strobe arrives while `ce_n` is high, while `oe_rst_n` is low, or after end of data does not move the counters.
- R6: A system-clock edge with `ctl_we` high loads the mode bit from `ctl_par`, where 1 selects byte mode and 0 selects serial mode. In byte mode the whole byte appears on `data_q[7:0]` and each valid edge advances the address by one.
- R7: The valid edge after the last item drives `ceo_n` low and `data_oe` low. The last item is byte DEPTH-1 bit 0 in serial mode, or byte DEPTH-1 in byte mode.
- R8: `data_oe` is high exactly when `ce_n` is low, `oe_rst_n` is high and end of data has not been reached. While `data_oe` is low, `data_q` reads 0.
- R9: A system-clock edge with `oe_rst_n` low returns the instance to byte 0 bit 7 and clears end of data.
- R10: With one instance's `ceo_n` driving the next one's `ce_n`, the two never drive in the same cycle. The second instance starts at its own byte 0 bit 7.
- R11: A rising edge of `cfg_req` with no pulse in progress drives `rcfg_n` low for exactly PULSE_NS*1000/CLK_PERIOD_PS system cycles (100 cycles = 400 ns by default). Requests made during a pulse are ignored.
- R12: `ceo_n` stays high while `ce_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_clk | input | 1 | External configuration clock, asynchronous |
| ce_n | input | 1 | Active-low chip enable |
| oe_rst_n | input | 1 | Active-low output enable and counter reset |
| ctl_we | input | 1 | Load strobe for the mode bit |
| ctl_par | input | 1 | Mode value: 1 byte mode, 0 serial |
| cfg_req | input | 1 | Reconfiguration request, rising-edge triggered |
| data_q | output | 8 | Output value: bit 0 in serial mode, whole byte in byte mode |
| data_oe | output | 1 | Drive enable of the shared data line |
| ceo_n | output | 1 | Active-low cascade enable to the next instance |
| rcfg_n | output | 1 | Active-low reconfigure pulse |

## Verification
The bench targets the handover edge. A design that advanced the downstream instance on that same edge would skip the second device's first bit. One that dropped the drive a cycle late would leave both instances driving the line. Edges that arrive while chip enable is high are checked with a byte whose skipped bits differ, so a reader that counts ignored edges shows a wrong bit. The bench also checks synchronizer latency at a 0-to-1 bit change. Finally, it sends a second request in the middle of the reconfigure pulse: a pulse generator that restarted on it would run past the exact width.

// File: rtl/cfgrd_pkg.sv
`timescale 1ns/1ps
package cfgrd_pkg;

  typedef enum logic {
    MODE_SERIAL = 1'b0,
    MODE_BYTE   = 1'b1
  } out_mode_e;

  // Fixed array content: an affine pattern of the byte address.
  function automatic logic [7:0] content_byte(input int unsigned addr, input logic [7:0] seed);
    int unsigned v;
    v = (addr * 29 + 32'(seed)) % 256;
    return v[7:0];
  endfunction

endpackage

// File: rtl/cfgrd_edge_sync.sv
`timescale 1ns/1ps
module cfgrd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], async_in};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/cfgrd_array.sv
`timescale 1ns/1ps
module cfgrd_array import cfgrd_pkg::*; #(
  parameter int          DEPTH  = 16,
  parameter int          ADDR_W = 4,
  parameter logic [7:0]  SEED   = 8'h5A
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [7:0]        byte_o
);

  logic [7:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign rom[i] = content_byte(i, SEED);
  end

  assign byte_o = rom[addr_i];

endmodule

// File: rtl/cfgrd_seq.sv
`timescale 1ns/1ps
module cfgrd_seq #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_i,
  input  logic              ce_n_i,
  input  logic              oe_rst_n_i,
  input  logic              byte_mode_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [2:0]        bit_o,
  output logic              done_o
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [2:0]        bit_q, bit_d;
  logic              done_q, done_d;
  logic              step_en, byte_end;

  assign step_en  = stb_i & ~ce_n_i & ~done_q;
  assign byte_end = byte_mode_i | (bit_q == 3'd7);

  always_comb begin
    addr_d = addr_q;
    bit_d  = bit_q;
    done_d = done_q;
    if (!oe_rst_n_i) begin
      addr_d = '0;
      bit_d  = '0;
      done_d = 1'b0;
    end else if (step_en) begin
      if (byte_end) begin
        bit_d = '0;
        if (addr_q == LAST_ADDR) begin
          done_d = 1'b1;
        end else begin
          addr_d = addr_q + 1'b1;
        end
      end else begin
        bit_d = bit_q + 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      bit_q  <= bit_d;
      done_q <= done_d;
    end
  end

  assign addr_o = addr_q;
  assign bit_o  = bit_q;
  assign done_o = done_q;

endmodule

// File: rtl/cfgrd_pulse.sv
`timescale 1ns/1ps
module cfgrd_pulse #(
  parameter int PULSE_CYC = 100,
  parameter int CNT_W     = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic pulse_n_o
);

  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYC);

  logic             req_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else if (req_i && !req_q) begin
      cnt_d = LOAD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      req_q <= req_i;
      cnt_q <= cnt_d;
    end
  end

  assign pulse_n_o = (cnt_q == '0);

endmodule

// File: rtl/cfg_stream_reader.sv
`timescale 1ns/1ps
module cfg_stream_reader import cfgrd_pkg::*; #(
  parameter int         DEPTH         = 16,
  parameter logic [7:0] SEED          = 8'h5A,
  parameter int         SYNC_STAGES   = 2,
  parameter int         CLK_PERIOD_PS = 4000,
  parameter int         PULSE_NS      = 400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_clk,
  input  logic       ce_n,
  input  logic       oe_rst_n,
  input  logic       ctl_we,
  input  logic       ctl_par,
  input  logic       cfg_req,
  output logic [7:0] data_q,
  output logic       data_oe,
  output logic       ceo_n,
  output logic       rcfg_n
);

  localparam int ADDR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PULSE_CYC = (PULSE_NS * 1000) / CLK_PERIOD_PS;
  localparam int CNT_W     = $clog2(PULSE_CYC + 1);

  // Reset: asserted asynchronously, released on the second clock edge.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // Output mode bit.
  out_mode_e mode_q, mode_d;
  logic      byte_mode;

  always_comb begin
    mode_d = mode_q;
    if (ctl_we) mode_d = ctl_par ? MODE_BYTE : MODE_SERIAL;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) mode_q <= MODE_SERIAL;
    else             mode_q <= mode_d;
  end
  assign byte_mode = (mode_q == MODE_BYTE);

  logic              cclk_rise;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        bit_q;
  logic              done;
  logic [7:0]        cur_byte;
  logic              drive;

  cfgrd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .async_in (cfg_clk),
    .rise_o   (cclk_rise)
  );

  cfgrd_seq #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .stb_i       (cclk_rise),
    .ce_n_i      (ce_n),
    .oe_rst_n_i  (oe_rst_n),
    .byte_mode_i (byte_mode),
    .addr_o      (addr_q),
    .bit_o       (bit_q),
    .done_o      (done)
  );

  cfgrd_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .SEED(SEED)) u_array (
    .addr_i (addr_q),
    .byte_o (cur_byte)
  );

  cfgrd_pulse #(.PULSE_CYC(PULSE_CYC), .CNT_W(CNT_W)) u_pulse (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_i     (cfg_req),
    .pulse_n_o (rcfg_n)
  );

  assign drive = ~ce_n & oe_rst_n & ~done;

  always_comb begin
    data_q = '0;
    if (drive) begin
      if (byte_mode) data_q = cur_byte;
      else           data_q = {7'b0, cur_byte[3'd7 - bit_q]};
    end
  end

  assign data_oe = drive;
  assign ceo_n   = ~(done & ~ce_n);

endmodule

// File: rtl/cfgrd_checker.sv
`timescale 1ns/1ps
module cfgrd_checker #(
  parameter int ADDR_W    = 4,
  parameter int PULSE_CYC = 100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_rst_n,
  input logic [7:0]        data_q,
  input logic              data_oe,
  input logic              ceo_n,
  input logic              rcfg_n,
  input logic              byte_mode,
  input logic              stb,
  input logic [ADDR_W-1:0] addr,
  input logic [2:0]        bit_cnt,
  input logic              done
);

  logic [15:0] low_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_run_q <= '0;
    else if (rcfg_n) low_run_q <= '0;
    else             low_run_q <= low_run_q + 16'd1;
  end

  AST_NO_DRIVE_CE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) ce_n |-> !data_oe); // R8
  AST_RELEASE_AT_END: assert property (@(posedge clk) disable iff (!rst_n) !ceo_n |-> !data_oe); // R7
  AST_CEO_GATED: assert property (@(posedge clk) disable iff (!rst_n) ce_n |-> ceo_n); // R12
  AST_SERIAL_NARROW: assert property (@(posedge clk) disable iff (!rst_n) (data_oe && !byte_mode) |-> (data_q[7:1] == 7'd0)); // R3
  AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n) (oe_rst_n && !stb) |=> ($stable(addr) && $stable(bit_cnt))); // R5
  AST_OE_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) !oe_rst_n |=> (addr == '0 && bit_cnt == 3'd0 && !done)); // R9
  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n) low_run_q <= 16'(PULSE_CYC)); // R11
  AST_PULSE_EXACT: assert property (@(posedge clk) disable iff (!rst_n) $rose(rcfg_n) |-> (low_run_q == 16'(PULSE_CYC))); // R11

endmodule

bind cfg_stream_reader cfgrd_checker #(.ADDR_W(ADDR_W), .PULSE_CYC(PULSE_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .ce_n      (ce_n),
  .oe_rst_n  (oe_rst_n),
  .data_q    (data_q),
  .data_oe   (data_oe),
  .ceo_n     (ceo_n),
  .rcfg_n    (rcfg_n),
  .byte_mode (byte_mode),
  .stb       (cclk_rise),
  .addr      (addr_q),
  .bit_cnt   (bit_q),
  .done      (done)
);

// File: tb/sim_cfg_stream_reader.sv
`timescale 1ns/1ps
module sim_cfg_stream_reader;

  localparam int         DEPTH = 16;
  localparam int         SYNC  = 2;
  localparam int         PCYC  = 100;
  localparam logic [7:0] SEED0 = 8'h5A;
  localparam logic [7:0] SEED1 = 8'hC3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, cfg_clk = 1'b0, ce_n = 1'b0, oe_rst_n = 1'b1;
  logic ctl_we = 1'b0, ctl_par = 1'b0, cfg_req = 1'b0;
  logic [7:0] dq0, dq1;
  logic oe0, oe1, ceo0, ceo1, rc0, rc1;

  cfg_stream_reader #(.DEPTH(DEPTH), .SEED(SEED0), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_clk(cfg_clk), .ce_n(ce_n), .oe_rst_n(oe_rst_n),
    .ctl_we(ctl_we), .ctl_par(ctl_par), .cfg_req(cfg_req),
    .data_q(dq0), .data_oe(oe0), .ceo_n(ceo0), .rcfg_n(rc0));

  cfg_stream_reader #(.DEPTH(DEPTH), .SEED(SEED1), .SYNC_STAGES(SYNC)) u1 (
    .clk(clk), .rst_n(rst_n), .cfg_clk(cfg_clk), .ce_n(ceo0), .oe_rst_n(oe_rst_n),
    .ctl_we(ctl_we), .ctl_par(ctl_par), .cfg_req(1'b0),
    .data_q(dq1), .data_oe(oe1), .ceo_n(ceo1), .rcfg_n(rc1));

  int errors = 0;
  int checks = 0;
  bit cmp_en = 1'b0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int content(input int a, input int s);
    return (a * 29 + s) % 256;
  endfunction

  // ---------------- reference model ----------------
  int m_addr[2];
  int m_bit[2];
  bit m_done[2];
  bit m_par;
  int hist[SYNC+1];
  int rc_edges = 0;
  bit m_reqq;
  int m_pcnt;

  function automatic bit m_ce(input int k);
    if (k == 0) return ce_n;
    return !(m_done[0] && !ce_n);
  endfunction

  function automatic bit m_ceo(input int k);
    return !(m_done[k] && !m_ce(k));
  endfunction

  function automatic bit m_oe(input int k);
    return !m_ce(k) && oe_rst_n && !m_done[k];
  endfunction

  function automatic int m_dq(input int k);
    int b;
    if (!m_oe(k)) return 0;
    b = content(m_addr[k], (k == 0) ? int'(SEED0) : int'(SEED1));
    if (m_par) return b;
    return (b >> (7 - m_bit[k])) & 1;
  endfunction

  always @(posedge clk) begin
    bit in_rst, stb;
    bit ce_pre[2];
    in_rst = (rc_edges < 2) || !rst_n;
    if (!rst_n) rc_edges = 0;
    else if (rc_edges < 2) rc_edges++;
    if (in_rst) begin
      for (int k = 0; k < 2; k++) begin m_addr[k] = 0; m_bit[k] = 0; m_done[k] = 0; end
      for (int i = 0; i <= SYNC; i++) hist[i] = 0;
      m_par = 0; m_reqq = 0; m_pcnt = 0;
    end else begin
      stb = (hist[SYNC-1] != 0) && (hist[SYNC] == 0);
      ce_pre[0] = m_ce(0);
      ce_pre[1] = m_ce(1);
      for (int k = 0; k < 2; k++) begin
        if (!oe_rst_n) begin
          m_addr[k] = 0; m_bit[k] = 0; m_done[k] = 0;
        end else if (stb && !ce_pre[k] && !m_done[k]) begin
          if (m_par || m_bit[k] == 7) begin
            m_bit[k] = 0;
            if (m_addr[k] == DEPTH - 1) m_done[k] = 1;
            else m_addr[k]++;
          end else begin
            m_bit[k]++;
          end
        end
      end
      if (ctl_we) m_par = ctl_par;
      for (int i = SYNC; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = cfg_clk;
      if (m_pcnt > 0) m_pcnt--;
      else if (cfg_req && !m_reqq) m_pcnt = PCYC;
      m_reqq = cfg_req;
    end
  end

  // Per-cycle comparison, away from the active edge.
  always begin
    @(negedge clk);
    #1;
    if (cmp_en) begin
      chk(int'(dq0) == m_dq(0), m_par ? "R6 data u0" : "R3 data u0", dq0, m_dq(0));
      chk(int'(dq1) == m_dq(1), m_par ? "R6 data u1" : "R3 data u1", dq1, m_dq(1));
      chk(oe0 == m_oe(0), "R8 drive u0", oe0, m_oe(0));
      chk(oe1 == m_oe(1), "R8 drive u1", oe1, m_oe(1));
      chk(ceo0 == m_ceo(0), "R7 cascade u0", ceo0, m_ceo(0));
      chk(ceo1 == m_ceo(1), "R7 cascade u1", ceo1, m_ceo(1));
      chk(!(oe0 && oe1), "R10 contention", {oe0, oe1}, 0);
      chk(rc0 == (m_pcnt == 0), "R11 reconfig", rc0, m_pcnt == 0);
    end
  end

  // ---------------- stimulus ----------------
  task automatic step();
    @(negedge clk);
  endtask

  task automatic cclk();
    cfg_clk = 1'b1;
    repeat (4) step();
    cfg_clk = 1'b0;
    repeat (4) step();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int lows;
    repeat (4) step();
    rst_n = 1'b1;
    repeat (3) step();
    cmp_en = 1'b1;

    // R1 reset state
    chk(oe0 == 1'b1, "R1 drive after reset", oe0, 1);
    chk(dq0 == 8'h00, "R1 first bit (byte0 bit7)", dq0, 0);
    chk(ceo0 == 1'b1 && rc0 == 1'b1, "R1 ceo/rcfg high", {ceo0, rc0}, 3);
    chk(oe1 == 1'b0, "R1 downstream idle", oe1, 0);

    // R4 synchronizer latency: byte0 bit7=0, bit6=1
    cfg_clk = 1'b1;
    step(); step();
    chk(dq0[0] == 1'b0, "R4 no change after two edges", dq0[0], 0);
    step();
    chk(dq0[0] == 1'b1, "R4 change on third edge", dq0[0], 1);
    step();
    cfg_clk = 1'b0;
    repeat (4) step();

    // R9 output-enable/reset clears position (was at bit6 = 1)
    oe_rst_n = 1'b0;
    step();
    chk(oe0 == 1'b0, "R8 released while oe_rst_n low", oe0, 0);
    oe_rst_n = 1'b1;
    step();
    chk(dq0 == 8'h00, "R9 restart at byte0 bit7", dq0, 0);

    // R2 / R3 assemble byte 0 MSB first
    v = '0;
    for (int i = 0; i < 8; i++) begin
      v = {v[6:0], dq0[0]};
      cclk();
    end
    chk(v == 8'(content(0, SEED0)), "R2 byte0 assembled", v, content(0, SEED0));

    // R5 edges with ce_n high are ignored (byte1=0x77: bit7=0, bit5=1)
    ce_n = 1'b1;
    step();
    chk(oe0 == 1'b0, "R8 no drive with ce_n high", oe0, 0);
    chk(ceo0 == 1'b1, "R12 ceo_n high with ce_n high", ceo0, 1);
    cclk();
    cclk();
    ce_n = 1'b0;
    step();
    chk(dq0[0] == 1'b0, "R5 position kept over ignored edges", dq0[0], 0);

    // R7 / R10 rest of stream and handover
    for (int i = 0; i < 119; i++) cclk();
    chk(ceo0 == 1'b1 && oe0 == 1'b1, "R7 still driving on last bit", {ceo0, oe0}, 3);
    cclk();
    chk(ceo0 == 1'b0, "R7 cascade asserted after last bit", ceo0, 0);
    chk(oe0 == 1'b0, "R7 upstream released", oe0, 0);
    chk(oe1 == 1'b1, "R10 downstream drives", oe1, 1);
    v = '0;
    for (int i = 0; i < 8; i++) begin
      v = {v[6:0], dq1[0]};
      cclk();
    end
    chk(v == 8'(content(0, SEED1)), "R10 downstream starts at its byte0", v, content(0, SEED1));

    // R6 byte mode
    ctl_par = 1'b1;
    ctl_we  = 1'b1;
    step();
    ctl_we  = 1'b0;
    oe_rst_n = 1'b0;
    step();
    oe_rst_n = 1'b1;
    step();
    for (int a = 0; a < DEPTH; a++) begin
      chk(int'(dq0) == content(a, SEED0), "R6 byte stream", dq0, content(a, SEED0));
      cclk();
    end
    chk(ceo0 == 1'b0, "R7 cascade after last byte", ceo0, 0);
    chk(int'(dq1) == content(0, SEED1), "R6 downstream first byte", dq1, content(0, SEED1));

    // back to serial
    ctl_par = 1'b0;
    ctl_we  = 1'b1;
    step();
    ctl_we  = 1'b0;
    oe_rst_n = 1'b0;
    step();
    oe_rst_n = 1'b1;
    step();
    chk(dq0 == 8'h00 && oe0 == 1'b1, "R3 serial after mode change", dq0, 0);

    // R11 reconfigure pulse, second request inside the pulse
    lows = 0;
    for (int i = 0; i < 300; i++) begin
      step();
      if (rc0 == 1'b0) lows++;
      if (i == 0)  cfg_req = 1'b1;
      if (i == 10) cfg_req = 1'b0;
      if (i == 20) cfg_req = 1'b1;
      if (i == 30) cfg_req = 1'b0;
    end
    chk(lows == PCYC, "R11 pulse width", lows, PCYC);

    finished = 1'b1;
    cmp_en = 1'b0;
    summary();
    $finish;
  end

endmodule